// File: doc/BRIEF.md
# Per-Bit Multi-Output Interrupt Router

This block gathers 32 level-style interrupt source lines into a set of ten dedicated interrupt outputs. The low-order source bit i owns output i. A rising edge on an enabled source line posts that bit into a status word and raises its output. Software services each bit on its own. It writes a one to the status bit to acknowledge it. Any event that arrived while that bit was busy is then replayed into status, and the output stays high. If nothing is waiting, the output drops. Because every bit keeps its own status, pending and output state, a slow handler on one source never holds back the others.

Software reaches the block through a plain 32-bit register port with two registers: an enable word at offset 0x0 and a status word at offset 0x4. Each access is a full 32-bit word. The enable word accumulates: once set, an enable bit stays set until reset. The same register also carries a mask/unmask protocol. A write that adds no new enable bits is compared with the previously written value, and the bits that differ are either masked or unmasked. A masked bit still collects events, but only into its pending state. There is no streaming data path, so every pin is a plain control or status signal without handshake.

Top module: `pbit_irq_router`

## Requirements
- R1: After reset, all ten outputs are low, and reads of the enable word (offset 0x0) and the status word (offset 0x4) return 0.
- R2: A low-to-high transition on source line i (i below 10) whose bit is in the accumulated enable set sets status bit i and drives irq_out[i] high at the next clock edge, provided status bit i and mask bit i are both clear. A line that stays high produces no further event, and a line outside the enable set produces no effect.
- R3: If such an event arrives while status bit i or mask bit i is set, pending bit i is set instead, and status bit i and irq_out[i] are left unchanged.
- R4: Posting, clearing and replay of one bit leave the status, pending and output state of every other bit unchanged.
- R5: A nonzero write to the status word clears every status bit written as 1. A write of 0 to the status word changes nothing.
- R6: For each bit i below 10 written as 1 in a status write other than 0xFFFFFFFF, the following applies. If pending bit i is set, status bit i is set again, pending bit i is cleared and irq_out[i] stays high. Otherwise irq_out[i] is driven low.
- R7: A status write of 0xFFFFFFFF clears the whole status word and performs no replay. Pending bits and all outputs keep their values.
- R8: A write to the enable word whose data adds at least one bit to the accumulated enable set ORs the data into that set and stores the data as the readable enable value, without touching the mask. Bits in the enable set are never removed.
- R9: An enable write that adds no new bit computes the difference between the stored enable value and the data. If any bit of that difference is also set in the data, those difference bits are unmasked. Otherwise they are masked. The data then becomes the stored enable value.
- R10: Events on source lines 10 to 31 post nothing, even when enabled. The status word bits 31..10 always read 0.
- R11: Reads at offset 0x0 return the stored enable value, and reads at offset 0x4 return the status word. Any other offset reads 0, and writes to it change no state.
- R12: When a status write and a source event for the same bit fall in the same cycle, the write is applied first, and the event is then judged against the post-write status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lines | input | 32 | Interrupt source lines, sampled for rising edges |
| bus_wr | input | 1 | Register write strobe, one word per cycle |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 10 | Per-bit interrupt outputs |

## Verification
The posting path is exercised in three ways: single isolated edges, a line held high for several cycles, and events that collide with a busy bit. Together these separate edge detection from level sensing and separate posting from pending capture. Status writes are tried with a single bit, a zero word, the all-ones word, and a write coinciding with a fresh edge. These show that replay is per bit, that the all-ones write suppresses replay, and that the write is ordered before capture. Enable writes that add bits, drop a bit, and restore it show the sticky set apart from the mask toggle. Enabled events on lines 10 and above, and accesses to an unmapped offset, confirm that neither leaks into status.

// File: rtl/pbit_irq_pkg.sv
package pbit_irq_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h4;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_ENABLE,
    REG_STATUS
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
    if (ofs == OFS_ENABLE) return REG_ENABLE;
    if (ofs == OFS_STATUS) return REG_STATUS;
    return REG_NONE;
  endfunction
endpackage

// File: rtl/pbit_irq_enable.sv
module pbit_irq_enable #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_reg_o,
  output logic [W-1:0] en_set_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] en_reg_q, en_set_q, mask_q;
  logic [W-1:0] grown, delta;

  always_comb begin
    grown = en_set_q | wdata_i;
    delta = en_reg_q ^ wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_reg_q <= '0;
      en_set_q <= '0;
      mask_q   <= '0;
    end else if (wr_i) begin
      if (wdata_i == '0 && en_set_q == '0) begin
        en_reg_q <= '0;
      end else if (grown != en_set_q) begin
        // new sources join the set; mask untouched
        en_set_q <= grown;
        en_reg_q <= wdata_i;
      end else begin
        // no new source: differing bits toggle the mask
        if (|(delta & wdata_i)) mask_q <= mask_q & ~delta;
        else                    mask_q <= mask_q | delta;
        en_reg_q <= wdata_i;
      end
    end
  end

  assign en_reg_o = en_reg_q;
  assign en_set_o = en_set_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/pbit_irq_edge.sv
module pbit_irq_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] en_set_i,
  output logic [W-1:0] sel_o
);
  logic [W-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_i;
  end

  assign sel_o = src_i & ~src_q & en_set_i;
endmodule

// File: rtl/pbit_irq_slice.sv
module pbit_irq_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic msk_i,
  input  logic clr_i,
  input  logic replay_i,
  output logic st_o,
  output logic pd_o,
  output logic irq_o
);
  logic st_q, pd_q, irq_q;
  logic st_n, pd_n, irq_n;

  always_comb begin
    st_n  = st_q;
    pd_n  = pd_q;
    irq_n = irq_q;
    // bus write first
    if (clr_i) st_n = 1'b0;
    if (replay_i) begin
      if (pd_q) begin
        st_n  = 1'b1;
        pd_n  = 1'b0;
        irq_n = 1'b1;
      end else begin
        irq_n = 1'b0;
      end
    end
    // then the source event, against post-write status
    if (sel_i) begin
      if (msk_i || st_n) begin
        pd_n = 1'b1;
      end else begin
        st_n  = 1'b1;
        irq_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 1'b0;
      pd_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      pd_q  <= pd_n;
      irq_q <= irq_n;
    end
  end

  assign st_o  = st_q;
  assign pd_o  = pd_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/pbit_irq_router.sv
module pbit_irq_router
  import pbit_irq_pkg::*;
#(
  parameter int unsigned SRC_W = 32,
  parameter int unsigned N_OUT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_lines,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SRC_W-1:0]  bus_wdata,
  output logic [SRC_W-1:0]  bus_rdata,
  output logic [N_OUT-1:0]  irq_out
);
  localparam int unsigned PAD_W = SRC_W - N_OUT;

  reg_sel_e         rsel;
  logic             wr_en, wr_st, wr_replay;
  logic [SRC_W-1:0] en_reg, en_set, mask_all, sel_all;
  logic [N_OUT-1:0] st_vec, pd_vec;
  logic             unused_hi;

  assign rsel      = decode_ofs(bus_addr);
  assign wr_en     = bus_wr && (rsel == REG_ENABLE);
  assign wr_st     = bus_wr && (rsel == REG_STATUS) && (bus_wdata != '0);
  assign wr_replay = wr_st && (bus_wdata != '1);

  pbit_irq_enable #(.W(SRC_W)) u_enable (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_en),
    .wdata_i  (bus_wdata),
    .en_reg_o (en_reg),
    .en_set_o (en_set),
    .mask_o   (mask_all)
  );

  pbit_irq_edge #(.W(SRC_W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_lines),
    .en_set_i (en_set),
    .sel_o    (sel_all)
  );

  // sources at or above N_OUT have no slice
  assign unused_hi = ^{sel_all[SRC_W-1:N_OUT], mask_all[SRC_W-1:N_OUT]};

  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    pbit_irq_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (sel_all[i]),
      .msk_i    (mask_all[i]),
      .clr_i    (wr_st && bus_wdata[i]),
      .replay_i (wr_replay && bus_wdata[i]),
      .st_o     (st_vec[i]),
      .pd_o     (pd_vec[i]),
      .irq_o    (irq_out[i])
    );
  end

  always_comb begin
    unique case (rsel)
      REG_ENABLE: bus_rdata = en_reg;
      REG_STATUS: bus_rdata = {{PAD_W{1'b0}}, st_vec};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pbit_irq_router_chk.sv
module pbit_irq_router_chk #(
  parameter int unsigned SRC_W = 32,
  parameter int unsigned N_OUT = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] src_lo,
  input logic             bus_wr,
  input logic [3:0]       bus_addr,
  input logic [SRC_W-1:0] bus_wdata,
  input logic [N_OUT-1:0] irq_out,
  input logic [N_OUT-1:0] st_vec,
  input logic [N_OUT-1:0] pd_vec,
  input logic [SRC_W-1:0] en_set
);
  logic [N_OUT-1:0] src_prev, raw_rise, en_rise, wr_bits;
  logic             stw, stw_part, st_zero, st_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev <= '0;
    else        src_prev <= src_lo;
  end

  assign raw_rise = src_lo & ~src_prev;
  assign en_rise  = raw_rise & en_set[N_OUT-1:0];
  assign stw      = bus_wr && bus_addr == 4'h4 && bus_wdata != '0;
  assign stw_part = stw && bus_wdata != '1;
  assign st_zero  = bus_wr && bus_addr == 4'h4 && bus_wdata == '0;
  assign st_full  = bus_wr && bus_addr == 4'h4 && bus_wdata == '1;
  assign wr_bits  = stw ? bus_wdata[N_OUT-1:0] : '0;

  // R2: an output only rises after an edge or a status write to its bit
  p_irq_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~$past(irq_out) & ~$past(raw_rise) & ~$past(wr_bits)) == '0);

  // R3: event on a busy bit goes to pending
  p_busy_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stw && (en_rise & st_vec) != '0) |=>
      ((pd_vec & st_vec & $past(en_rise & st_vec)) == $past(en_rise & st_vec)));

  // R5: zero status write is ignored
  p_zero_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_zero && raw_rise == '0) |=>
      ($stable(irq_out) && $stable(st_vec) && $stable(pd_vec)));

  // R6: acknowledged bit with nothing pending drops its output
  p_release_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stw_part && raw_rise == '0) |=>
      ((irq_out & $past(bus_wdata[N_OUT-1:0] & ~pd_vec)) == '0));

  // R7: all-ones write clears status, no replay
  p_full_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && raw_rise == '0) |=>
      (st_vec == '0 && $stable(irq_out) && $stable(pd_vec)));

  // R8: enable set never loses bits
  p_sticky_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set & $past(en_set)) == $past(en_set));
endmodule

bind pbit_irq_router pbit_irq_router_chk #(.SRC_W(SRC_W), .N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_lo    (src_lines[N_OUT-1:0]),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_out   (irq_out),
  .st_vec    (st_vec),
  .pd_vec    (pd_vec),
  .en_set    (en_set)
);

// File: tb/tb_pbit_irq_router.sv
`timescale 1ns/1ps
module tb_pbit_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pbit_irq_router dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lines (src),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] bits);
    @(negedge clk);
    src = src | bits;
    @(negedge clk);
    src = src & ~bits;
    @(negedge clk);
  endtask

  task automatic expect_state(input string tag, input logic [31:0] st, input logic [9:0] irq);
    logic [31:0] r;
    rd_reg(4'h4, r);
    check({tag, " status"}, r, st);
    check({tag, " irq"}, {22'd0, irq_out}, {22'd0, irq});
  endtask

  task automatic t_reset;
    logic [31:0] r;
    check("R1 irq", {22'd0, irq_out}, 32'd0);
    rd_reg(4'h0, r); check("R1 enable", r, 32'd0);
    rd_reg(4'h4, r); check("R1 status", r, 32'd0);
  endtask

  task automatic t_post;
    logic [31:0] r;
    wr_reg(4'h0, 32'h3);
    rd_reg(4'h0, r); check("R8 enable readback", r, 32'h3);
    pulse(32'h1);
    expect_state("R2 post line0", 32'h1, 10'h1);
    pulse(32'h4);
    expect_state("R2 disabled line2", 32'h1, 10'h1);
  endtask

  task automatic t_busy_replay;
    pulse(32'h1);
    expect_state("R3 busy bit0", 32'h1, 10'h1);
    wr_reg(4'h4, 32'h1);
    expect_state("R6 replay bit0", 32'h1, 10'h1);
    wr_reg(4'h4, 32'h1);
    expect_state("R6 release bit0", 32'h0, 10'h0);
  endtask

  task automatic t_independent;
    pulse(32'h1);
    pulse(32'h2);
    expect_state("R2 two bits", 32'h3, 10'h3);
    wr_reg(4'h4, 32'h2);
    expect_state("R4 bit1 ack keeps bit0", 32'h1, 10'h1);
    wr_reg(4'h4, 32'h0);
    expect_state("R5 zero write", 32'h1, 10'h1);
    wr_reg(4'h4, 32'h1);
    expect_state("R5 clear bit0", 32'h0, 10'h0);
  endtask

  task automatic t_hold;
    @(negedge clk); src = src | 32'h1;
    repeat (3) @(negedge clk);
    expect_state("R2 held line posts once", 32'h1, 10'h1);
    wr_reg(4'h4, 32'h1);
    repeat (2) @(negedge clk);
    expect_state("R2 held line no repost", 32'h0, 10'h0);
    src = src & ~32'h1;
    @(negedge clk);
  endtask

  task automatic t_mask;
    logic [31:0] r;
    wr_reg(4'h0, 32'h1);
    rd_reg(4'h0, r); check("R9 enable stored", r, 32'h1);
    pulse(32'h2);
    expect_state("R9 masked bit1 goes pending", 32'h0, 10'h0);
    wr_reg(4'h0, 32'h3);
    pulse(32'h2);
    expect_state("R9 unmasked bit1 posts", 32'h2, 10'h2);
    wr_reg(4'h4, 32'h2);
    expect_state("R3 pending kept under mask replays", 32'h2, 10'h2);
    wr_reg(4'h4, 32'h2);
    expect_state("R6 bit1 released", 32'h0, 10'h0);
  endtask

  task automatic t_full_clear;
    pulse(32'h1);
    pulse(32'h1);
    wr_reg(4'h4, 32'hFFFF_FFFF);
    expect_state("R7 all-ones no replay", 32'h0, 10'h1);
    wr_reg(4'h4, 32'h1);
    expect_state("R7 pending survives", 32'h1, 10'h1);
    wr_reg(4'h4, 32'h1);
    expect_state("R7 cleanup", 32'h0, 10'h0);
  endtask

  task automatic t_high_lines;
    logic [31:0] r;
    wr_reg(4'h0, 32'h0000_0C00);
    rd_reg(4'h0, r); check("R8 new bits stored", r, 32'h0000_0C00);
    pulse(32'h0000_0C00);
    expect_state("R10 lines 10,11 ignored", 32'h0, 10'h0);
    rd_reg(4'h8, r); check("R11 unmapped read", r, 32'h0);
    wr_reg(4'h8, 32'hFFFF_FFFF);
    rd_reg(4'h0, r); check("R11 unmapped write enable", r, 32'h0000_0C00);
    expect_state("R11 unmapped write status", 32'h0, 10'h0);
    pulse(32'h1);
    expect_state("R8 sticky bit0 still enabled", 32'h1, 10'h1);
    wr_reg(4'h4, 32'h1);
    expect_state("R8 cleanup", 32'h0, 10'h0);
  endtask

  task automatic t_same_cycle;
    pulse(32'h1);
    @(negedge clk);
    src = src | 32'h1;
    bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h1;
    @(negedge clk);
    bus_wr = 1'b0;
    src = src & ~32'h1;
    expect_state("R12 write before capture", 32'h1, 10'h1);
    wr_reg(4'h4, 32'h1);
    expect_state("R12 nothing pending", 32'h0, 10'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_post();
    t_busy_replay();
    t_independent();
    t_hold();
    t_mask();
    t_full_clear();
    t_high_lines();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule